// File: doc/BRIEF.md
# ASID-Tagged Translation Lookaside Buffer

This block is a small, fully associative translation cache. Each slot holds one mapping from a virtual page number to a physical frame number. The slot is tagged with the address-space identifier of the process that owns it, so mappings of several processes can stay resident at the same time. A lookup presents a page number, a page offset, the current identifier and the kind of access. One cycle later the block reports a hit or a miss. On a hit it also gives the physical address, the permission bits of the slot and a protection-fault flag.

After a miss, the surrounding logic walks the page table and installs the result through the fill port. A fill for a page and identifier that are already resident updates that slot in place. Any other fill takes a free slot if one exists, and otherwise a round-robin victim. Slots can be pinned so that replacement and flushes never remove them. Two flush inputs clear either every unpinned slot or only the unpinned slots of one identifier.

Top module: `asid_tlb`

## Requirements
- R1: While reset is asserted and after its release, `rs_valid` is low, and every lookup made before the first fill misses.
- R2: `rs_valid` is high in the cycle after a cycle with `lk_valid` high, and low in the cycle after a cycle with `lk_valid` low.
- R3: A lookup hits only when a valid slot matches both the page number and the identifier. On a hit, `rs_paddr` is the slot's frame number in the upper PFN_W bits, with `lk_off` unchanged in the lower OFF_W bits.
- R4: On a hit, `rs_fault` is high if the access is a write (`lk_write`) and the slot's `rs_writable` bit is 0, or if the access is a fetch (`lk_exec`) and the slot's `rs_exec` bit is 0. A miss never raises `rs_fault`.
- R5: A fill makes the mapping hit from the next cycle on. A lookup presented in the same cycle as the fill sees the contents from before the fill.
- R6: A fill whose page number and identifier are already resident overwrites that slot, so the lookup returns only the new frame and permissions.
- R7: A fill that is not an update takes the lowest-indexed slot that is free and unpinned. When no such slot exists, it takes the first unpinned slot at or after the round-robin pointer, wrapping around. The pointer then moves to the slot after the one just filled.
- R8: A pinned slot (`pin_valid` with `pin_set`=1 for `pin_idx`; `pin_set`=0 unpins it) is never chosen as a victim and is never cleared by either flush.
- R9: `fl_asid_en` clears every unpinned slot whose identifier equals `fl_asid`, and leaves all other slots unchanged.
- R10: `fl_all` clears every unpinned slot. When a flush and a fill arrive in the same cycle, the flush is applied and the fill is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lk_valid | input | 1 | Lookup request |
| lk_vpn | input | VPN_W | Virtual page number to translate |
| lk_off | input | OFF_W | Page offset, passed through |
| lk_asid | input | ASID_W | Identifier of the current process |
| lk_write | input | 1 | Access is a write |
| lk_exec | input | 1 | Access is an instruction fetch |
| rs_valid | output | 1 | Lookup result present |
| rs_hit | output | 1 | Translation found |
| rs_paddr | output | PFN_W+OFF_W | Physical address |
| rs_writable | output | 1 | Slot allows writes |
| rs_exec | output | 1 | Slot allows execution |
| rs_fault | output | 1 | Access violates the slot's permissions |
| fill_valid | input | 1 | Install a translation |
| fill_vpn | input | VPN_W | Page number to install |
| fill_asid | input | ASID_W | Owning identifier |
| fill_pfn | input | PFN_W | Frame number |
| fill_writable | input | 1 | Write permission |
| fill_exec | input | 1 | Execute permission |
| pin_valid | input | 1 | Update the pin bit of one slot |
| pin_idx | input | IDX_W | Slot index to pin or unpin |
| pin_set | input | 1 | 1 pins, 0 unpins |
| fl_all | input | 1 | Clear all unpinned slots |
| fl_asid_en | input | 1 | Clear the unpinned slots of one identifier |
| fl_asid | input | ASID_W | Identifier to flush |

## Verification
The case that is hardest to reach from the ports is round-robin eviction past a pinned slot. Reaching it requires every slot to be valid, so that the free-slot path is no longer taken, with a pinned slot sitting directly at the pointer. The bench fills all sixteen slots, which leaves the pointer wrapped to slot 0, and pins slot 1. It then installs two new mappings. The first must evict slot 0 and the second must skip slot 1 and evict slot 2. This is observed only through which older mappings still hit. A duplicate fill is made visible through the frame value, because a second matching slot would corrupt the one-hot read-out.

// File: rtl/tlb_pkg.sv
package tlb_pkg;
  typedef struct packed {
    logic wr;
    logic ex;
  } perm_t;

  typedef enum logic [1:0] {
    FILL_NONE,
    FILL_UPDATE,
    FILL_NEW,
    FILL_DROP
  } fill_kind_e;
endpackage

// File: rtl/tlb_match.sv
module tlb_match #(
  parameter int N      = 16,
  parameter int VPN_W  = 20,
  parameter int ASID_W = 8
) (
  input  logic [N-1:0]             valid,
  input  logic [N-1:0][VPN_W-1:0]  vpn,
  input  logic [N-1:0][ASID_W-1:0] asid,
  input  logic [VPN_W-1:0]         key_vpn,
  input  logic [ASID_W-1:0]        key_asid,
  output logic [N-1:0]             match
);
  for (genvar g = 0; g < N; g++) begin : g_cmp
    assign match[g] = valid[g] && (vpn[g] == key_vpn) && (asid[g] == key_asid);
  end
endmodule

// File: rtl/tlb_victim.sv
module tlb_victim #(
  parameter int N = 16,
  localparam int IDX_W = $clog2(N)
) (
  input  logic [N-1:0]     valid,
  input  logic [N-1:0]     wired,
  input  logic [IDX_W-1:0] ptr,
  output logic             found,
  output logic [IDX_W-1:0] idx
);
  always_comb begin
    int j;
    found = 1'b0;
    idx   = '0;
    j     = 0;
    for (int k = N - 1; k >= 0; k--) begin
      if (!valid[k] && !wired[k]) begin
        found = 1'b1;
        idx   = IDX_W'(k);
      end
    end
    if (!found) begin
      for (int k = N - 1; k >= 0; k--) begin
        j = (int'(ptr) + k) % N;
        if (!wired[j]) begin
          found = 1'b1;
          idx   = IDX_W'(j);
        end
      end
    end
  end
endmodule

// File: rtl/asid_tlb.sv
module asid_tlb
  import tlb_pkg::*;
#(
  parameter int ENTRIES = 16,
  parameter int VPN_W   = 20,
  parameter int PFN_W   = 20,
  parameter int OFF_W   = 12,
  parameter int ASID_W  = 8,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   lk_valid,
  input  logic [VPN_W-1:0]       lk_vpn,
  input  logic [OFF_W-1:0]       lk_off,
  input  logic [ASID_W-1:0]      lk_asid,
  input  logic                   lk_write,
  input  logic                   lk_exec,
  output logic                   rs_valid,
  output logic                   rs_hit,
  output logic [PFN_W+OFF_W-1:0] rs_paddr,
  output logic                   rs_writable,
  output logic                   rs_exec,
  output logic                   rs_fault,
  input  logic                   fill_valid,
  input  logic [VPN_W-1:0]       fill_vpn,
  input  logic [ASID_W-1:0]      fill_asid,
  input  logic [PFN_W-1:0]       fill_pfn,
  input  logic                   fill_writable,
  input  logic                   fill_exec,
  input  logic                   pin_valid,
  input  logic [IDX_W-1:0]       pin_idx,
  input  logic                   pin_set,
  input  logic                   fl_all,
  input  logic                   fl_asid_en,
  input  logic [ASID_W-1:0]      fl_asid
);
  // slot state
  logic [ENTRIES-1:0]             valid_q, valid_d;
  logic [ENTRIES-1:0]             wired_q, wired_d;
  logic [ENTRIES-1:0][VPN_W-1:0]  vpn_q, vpn_d;
  logic [ENTRIES-1:0][ASID_W-1:0] asid_q, asid_d;
  logic [ENTRIES-1:0][PFN_W-1:0]  pfn_q, pfn_d;
  perm_t [ENTRIES-1:0]            perm_q, perm_d;
  logic [IDX_W-1:0]               rr_q, rr_d;

  // lookup result registers
  logic             rs_valid_q;
  logic             rs_hit_q, rs_hit_d;
  logic [PFN_W-1:0] rs_pfn_q, rs_pfn_d;
  logic [OFF_W-1:0] rs_off_q;
  perm_t            rs_perm_q, rs_perm_d;
  logic             rs_fault_q, rs_fault_d;

  logic [ENTRIES-1:0] lk_match, fill_match;
  logic               vic_found;
  logic [IDX_W-1:0]   vic_idx, upd_idx, wr_idx;
  fill_kind_e         fill_kind;

  tlb_match #(.N(ENTRIES), .VPN_W(VPN_W), .ASID_W(ASID_W)) u_lk_cmp (
    .valid(valid_q), .vpn(vpn_q), .asid(asid_q),
    .key_vpn(lk_vpn), .key_asid(lk_asid), .match(lk_match)
  );

  tlb_match #(.N(ENTRIES), .VPN_W(VPN_W), .ASID_W(ASID_W)) u_fill_cmp (
    .valid(valid_q), .vpn(vpn_q), .asid(asid_q),
    .key_vpn(fill_vpn), .key_asid(fill_asid), .match(fill_match)
  );

  tlb_victim #(.N(ENTRIES)) u_victim (
    .valid(valid_q), .wired(wired_q), .ptr(rr_q),
    .found(vic_found), .idx(vic_idx)
  );

  // index of the resident copy for an in-place update
  always_comb begin
    upd_idx = '0;
    for (int k = ENTRIES - 1; k >= 0; k--) begin
      if (fill_match[k]) upd_idx = IDX_W'(k);
    end
  end

  // classify the fill request
  always_comb begin
    fill_kind = FILL_NONE;
    wr_idx    = vic_idx;
    if (fill_valid && !fl_all && !fl_asid_en) begin
      if (|fill_match) begin
        fill_kind = FILL_UPDATE;
        wr_idx    = upd_idx;
      end else if (vic_found) begin
        fill_kind = FILL_NEW;
      end else begin
        fill_kind = FILL_DROP;
      end
    end
  end

  // next state of the slot array
  always_comb begin
    valid_d = valid_q;
    wired_d = wired_q;
    vpn_d   = vpn_q;
    asid_d  = asid_q;
    pfn_d   = pfn_q;
    perm_d  = perm_q;
    rr_d    = rr_q;
    if (fl_all) begin
      valid_d = valid_q & wired_q;
    end else if (fl_asid_en) begin
      for (int k = 0; k < ENTRIES; k++) begin
        if (!wired_q[k] && asid_q[k] == fl_asid) valid_d[k] = 1'b0;
      end
    end else if (fill_kind == FILL_UPDATE || fill_kind == FILL_NEW) begin
      valid_d[wr_idx]   = 1'b1;
      vpn_d[wr_idx]     = fill_vpn;
      asid_d[wr_idx]    = fill_asid;
      pfn_d[wr_idx]     = fill_pfn;
      perm_d[wr_idx].wr = fill_writable;
      perm_d[wr_idx].ex = fill_exec;
      if (fill_kind == FILL_NEW) rr_d = IDX_W'(vic_idx + 1'b1);
    end
    if (pin_valid) wired_d[pin_idx] = pin_set;
  end

  // next lookup result
  always_comb begin
    rs_pfn_d  = '0;
    rs_perm_d = '0;
    for (int k = 0; k < ENTRIES; k++) begin
      if (lk_match[k]) begin
        rs_pfn_d  = rs_pfn_d | pfn_q[k];
        rs_perm_d = rs_perm_d | perm_q[k];
      end
    end
    rs_hit_d   = |lk_match;
    rs_fault_d = rs_hit_d && ((lk_write && !rs_perm_d.wr) || (lk_exec && !rs_perm_d.ex));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= '0;
      wired_q <= '0;
      vpn_q   <= '0;
      asid_q  <= '0;
      pfn_q   <= '0;
      perm_q  <= '0;
      rr_q    <= '0;
    end else begin
      valid_q <= valid_d;
      wired_q <= wired_d;
      vpn_q   <= vpn_d;
      asid_q  <= asid_d;
      pfn_q   <= pfn_d;
      perm_q  <= perm_d;
      rr_q    <= rr_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rs_valid_q <= 1'b0;
      rs_hit_q   <= 1'b0;
      rs_pfn_q   <= '0;
      rs_off_q   <= '0;
      rs_perm_q  <= '0;
      rs_fault_q <= 1'b0;
    end else begin
      rs_valid_q <= lk_valid;
      if (lk_valid) begin
        rs_hit_q   <= rs_hit_d;
        rs_pfn_q   <= rs_pfn_d;
        rs_off_q   <= lk_off;
        rs_perm_q  <= rs_perm_d;
        rs_fault_q <= rs_fault_d;
      end
    end
  end

  assign rs_valid    = rs_valid_q;
  assign rs_hit      = rs_valid_q && rs_hit_q;
  assign rs_paddr    = {rs_pfn_q, rs_off_q};
  assign rs_writable = rs_perm_q.wr;
  assign rs_exec     = rs_perm_q.ex;
  assign rs_fault    = rs_valid_q && rs_fault_q;
endmodule

// File: rtl/asid_tlb_chk.sv
module asid_tlb_chk #(
  parameter int N = 16
) (
  input logic         clk,
  input logic         rst_n,
  input logic         lk_valid,
  input logic         rs_valid,
  input logic         rs_hit,
  input logic         rs_fault,
  input logic         fl_all,
  input logic [N-1:0] valid_q,
  input logic [N-1:0] wired_q,
  input logic [N-1:0] lk_match,
  input logic [N-1:0] fill_match
);
  p_result_follows_req_r2: assert property (@(posedge clk) disable iff (!rst_n)
    lk_valid |=> rs_valid);
  p_no_result_without_req_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !lk_valid |=> !rs_valid);
  p_hit_only_with_result_r3: assert property (@(posedge clk) disable iff (!rst_n)
    rs_hit |-> rs_valid);
  p_fault_needs_hit_r4: assert property (@(posedge clk) disable iff (!rst_n)
    rs_fault |-> rs_hit);
  p_single_lookup_match_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(lk_match));
  p_single_fill_match_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(fill_match));
  p_pinned_kept_r8: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((valid_q & $past(wired_q & valid_q)) == $past(wired_q & valid_q)));
  p_flush_all_clears_r10: assert property (@(posedge clk) disable iff (!rst_n)
    fl_all |=> ((valid_q & ~$past(wired_q)) == '0));
endmodule

bind asid_tlb asid_tlb_chk #(.N(ENTRIES)) u_chk (
  .clk(clk), .rst_n(rst_n), .lk_valid(lk_valid), .rs_valid(rs_valid),
  .rs_hit(rs_hit), .rs_fault(rs_fault), .fl_all(fl_all),
  .valid_q(valid_q), .wired_q(wired_q), .lk_match(lk_match), .fill_match(fill_match)
);

// File: tb/sim_asid_tlb.sv
`timescale 1ns/1ps
module sim_asid_tlb;
  localparam int VPN_W = 20, PFN_W = 20, OFF_W = 12, ASID_W = 8, IDX_W = 4;
  localparam int VW = VPN_W + ASID_W + 1 + 1 + 1 + PFN_W + 1;
  // {vpn, asid, write, exec, exp_hit, exp_pfn, exp_fault}
  localparam logic [VW-1:0] VEC [9] = '{
    {20'h00010, 8'h01, 1'b0, 1'b0, 1'b1, 20'h0ABCD, 1'b0},
    {20'h00010, 8'h02, 1'b0, 1'b0, 1'b1, 20'h11111, 1'b0},
    {20'h00010, 8'h03, 1'b0, 1'b0, 1'b0, 20'h00000, 1'b0},
    {20'h00020, 8'h01, 1'b1, 1'b0, 1'b1, 20'h22222, 1'b1},
    {20'h00020, 8'h01, 1'b0, 1'b1, 1'b1, 20'h22222, 1'b1},
    {20'h00010, 8'h02, 1'b1, 1'b0, 1'b1, 20'h11111, 1'b1},
    {20'h00010, 8'h01, 1'b1, 1'b0, 1'b1, 20'h0ABCD, 1'b0},
    {20'h00030, 8'h01, 1'b1, 1'b1, 1'b0, 20'h00000, 1'b0},
    {20'h00010, 8'h02, 1'b0, 1'b1, 1'b1, 20'h11111, 1'b0}
  };

  logic clk, rst_n;
  logic lk_valid, lk_write, lk_exec;
  logic [VPN_W-1:0] lk_vpn;
  logic [OFF_W-1:0] lk_off;
  logic [ASID_W-1:0] lk_asid;
  logic rs_valid, rs_hit, rs_writable, rs_exec, rs_fault;
  logic [PFN_W+OFF_W-1:0] rs_paddr;
  logic fill_valid, fill_writable, fill_exec;
  logic [VPN_W-1:0] fill_vpn;
  logic [ASID_W-1:0] fill_asid;
  logic [PFN_W-1:0] fill_pfn;
  logic pin_valid, pin_set, fl_all, fl_asid_en;
  logic [IDX_W-1:0] pin_idx;
  logic [ASID_W-1:0] fl_asid;

  int n_checks = 0, n_fail = 0;
  bit done = 0;

  asid_tlb u0 (.*);

  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  endtask

  task automatic fill(input logic [VPN_W-1:0] v, input logic [ASID_W-1:0] a,
                      input logic [PFN_W-1:0] p, input logic w, input logic x);
    @(negedge clk);
    fill_valid = 1; fill_vpn = v; fill_asid = a; fill_pfn = p; fill_writable = w; fill_exec = x;
    @(negedge clk);
    fill_valid = 0;
  endtask

  task automatic lookup(input logic [VPN_W-1:0] v, input logic [OFF_W-1:0] o,
                        input logic [ASID_W-1:0] a, input logic w, input logic x);
    @(negedge clk);
    lk_valid = 1; lk_vpn = v; lk_off = o; lk_asid = a; lk_write = w; lk_exec = x;
    @(negedge clk);
    lk_valid = 0;
  endtask

  task automatic expect_hit(input logic [VPN_W-1:0] v, input logic [ASID_W-1:0] a,
                            input bit exp_hit, input logic [PFN_W-1:0] p, input string req);
    lookup(v, 12'h3C7, a, 0, 0);
    check(rs_hit == exp_hit, req, rs_hit, exp_hit);
    if (exp_hit) check(rs_paddr == {p, 12'h3C7}, req, rs_paddr, {p, 12'h3C7});
  endtask

  task automatic pin(input logic [IDX_W-1:0] i, input logic s);
    @(negedge clk);
    pin_valid = 1; pin_idx = i; pin_set = s;
    @(negedge clk);
    pin_valid = 0;
  endtask

  task automatic flush(input logic all, input logic [ASID_W-1:0] a);
    @(negedge clk);
    fl_all = all; fl_asid_en = !all; fl_asid = a;
    @(negedge clk);
    fl_all = 0; fl_asid_en = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    check(0, "watchdog", 0, 1);
    finish_run();
  end

  initial begin
    rst_n = 0; lk_valid = 0; lk_vpn = '0; lk_off = '0; lk_asid = '0; lk_write = 0; lk_exec = 0;
    fill_valid = 0; fill_vpn = '0; fill_asid = '0; fill_pfn = '0; fill_writable = 0; fill_exec = 0;
    pin_valid = 0; pin_idx = '0; pin_set = 0; fl_all = 0; fl_asid_en = 0; fl_asid = '0;
    repeat (3) @(negedge clk);
    check(rs_valid == 0, "R1 reset rs_valid", rs_valid, 0);
    rst_n = 1;
    @(negedge clk);
    check(rs_valid == 0, "R1 idle after reset", rs_valid, 0);
    lookup(20'h00010, 12'h000, 8'h01, 0, 0);
    check(rs_hit == 0, "R1 empty miss", rs_hit, 0);
    check(rs_valid == 1, "R2 result valid", rs_valid, 1);
    @(negedge clk);
    check(rs_valid == 0, "R2 result drops", rs_valid, 0);

    // fill in the same cycle as a lookup: lookup sees old contents (R5)
    @(negedge clk);
    fill_valid = 1; fill_vpn = 20'h00010; fill_asid = 8'h01; fill_pfn = 20'h0ABCD;
    fill_writable = 1; fill_exec = 0;
    lk_valid = 1; lk_vpn = 20'h00010; lk_off = 12'h001; lk_asid = 8'h01; lk_write = 0; lk_exec = 0;
    @(negedge clk);
    fill_valid = 0; lk_valid = 0;
    check(rs_hit == 0, "R5 same-cycle lookup sees old", rs_hit, 0);
    fill(20'h00010, 8'h02, 20'h11111, 0, 1);
    fill(20'h00020, 8'h01, 20'h22222, 0, 0);

    // table walk: R3 match on vpn+asid, R4 permissions
    for (int i = 0; i < 9; i++) begin
      logic [VPN_W-1:0] v; logic [ASID_W-1:0] a; logic w, x, eh, ef; logic [PFN_W-1:0] p;
      logic [OFF_W-1:0] o;
      {v, a, w, x, eh, p, ef} = VEC[i];
      o = OFF_W'(12'h100 + i);
      lookup(v, o, a, w, x);
      check(rs_hit == eh, "R3 hit", rs_hit, eh);
      check(rs_fault == ef, "R4 fault", rs_fault, ef);
      if (eh) check(rs_paddr == {p, o}, "R3 paddr", rs_paddr, {p, o});
    end

    // R6 duplicate fill overwrites
    fill(20'h00010, 8'h01, 20'h33333, 0, 1);
    lookup(20'h00010, 12'h0AA, 8'h01, 1, 0);
    check(rs_paddr == {20'h33333, 12'h0AA}, "R6 overwritten frame", rs_paddr, {20'h33333, 12'h0AA});
    check(rs_fault == 1, "R6 overwritten permissions", rs_fault, 1);

    // fill the remaining 13 slots (3..15), pin slot 1 (asid 2 mapping)
    for (int i = 0; i < 13; i++) fill(20'h00100 + 20'(i), 8'h05, 20'h40000 + 20'(i), 1, 1);
    pin(4'd1, 1);
    fill(20'h00200, 8'h05, 20'h50000, 1, 1);   // evicts slot 0
    fill(20'h00201, 8'h05, 20'h50001, 1, 1);   // skips pinned slot 1, evicts slot 2
    expect_hit(20'h00010, 8'h01, 0, '0, "R7 slot0 evicted");
    expect_hit(20'h00010, 8'h02, 1, 20'h11111, "R8 pinned survives eviction");
    expect_hit(20'h00020, 8'h01, 0, '0, "R7 slot2 evicted");
    expect_hit(20'h00200, 8'h05, 1, 20'h50000, "R7 new fill hits");
    expect_hit(20'h00201, 8'h05, 1, 20'h50001, "R5 new fill hits");
    expect_hit(20'h00103, 8'h05, 1, 20'h40003, "R7 other slot kept");

    // R9 flush by identifier
    flush(0, 8'h05);
    expect_hit(20'h00103, 8'h05, 0, '0, "R9 asid flushed");
    expect_hit(20'h00200, 8'h05, 0, '0, "R9 asid flushed");
    flush(0, 8'h02);
    expect_hit(20'h00010, 8'h02, 1, 20'h11111, "R8 pinned survives asid flush");

    // R10 flush all plus same-cycle fill discarded
    fill(20'h00300, 8'h07, 20'h60000, 0, 0);
    @(negedge clk);
    fl_all = 1; fill_valid = 1; fill_vpn = 20'h00301; fill_asid = 8'h07; fill_pfn = 20'h60001;
    @(negedge clk);
    fl_all = 0; fill_valid = 0;
    expect_hit(20'h00300, 8'h07, 0, '0, "R10 flush all clears");
    expect_hit(20'h00301, 8'h07, 0, '0, "R10 fill discarded");
    expect_hit(20'h00010, 8'h02, 1, 20'h11111, "R8 pinned survives flush all");
    pin(4'd1, 0);
    flush(1, 8'h00);
    expect_hit(20'h00010, 8'h02, 0, '0, "R8 unpinned then flushed");
    finish_run();
  end
endmodule